// File: doc/BRIEF.md
# UART Receiver with Character Timeout

This block turns an asynchronous serial line into characters. A one-cycle oversample enable, `os_tick`, paces it. A mode select sets 16, 8 or 4 ticks per bit. The receiver waits for a high-to-low transition and checks the start bit again at half a bit time. It then samples each data bit, the optional parity bit and the stop bit at the centre of its bit period. Each finished character is stored in a 16-entry queue together with three error tags: parity, framing and break.

The host reads the queue head from the output pins and removes it with a one-cycle `pop`. A data-ready timeout tells the host that characters are waiting even when no more arrive. An overrun flag reports a character that was lost because the queue was full.

Top module: `sio_rx_unit`

## Requirements
- R1: `os_mode` selects the ticks per bit: 00 gives 16, 01 gives 8, 10 and 11 give 4. Only cycles with `os_tick` high advance the receiver and the timeout counter, so a tick that comes only every few cycles stretches all timing in proportion.
- R2: A character begins when a tick sees `rxd` low after the previous tick saw it high. Half a bit time later the line is sampled again. If it is high, this is a false start: it is dropped, nothing is queued, and the receiver waits for the next high-to-low transition.
- R3: `word_sel` sets the data length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Each data bit is sampled at its centre. The first bit received goes to bit 0 of `rx_data`, and the bits above the selected length read as zero.
- R4: When `par_en` is 1, one parity bit follows the data. The parity tag is set when the data bits plus the parity bit have an odd count of ones and `par_odd` is 0, or an even count and `par_odd` is 1. When `par_en` is 0, the tag is 0.
- R5: The framing tag is set when the stop bit is sampled low.
- R6: The break tag is set when every data sample, the parity sample (if enabled) and the stop sample are low. Break always comes with the framing tag.
- R7: The queue holds 16 entries and returns them in arrival order. `rx_count` gives the number of entries held. `rx_valid` is high when at least one entry is held. The head outputs show the new head in the cycle after a pop.
- R8: A pop while the queue is empty has no effect.
- R9: A character that completes while 16 entries are held is discarded, and `rx_overrun` goes high. `rx_overrun` goes low on the next pop that removes an entry.
- R10: `rx_timeout` goes high after (4 x data length + 12) bit times of ticks with no completed character and no pop, while the queue is not empty. Each completed character and each pop restarts the count. A pop clears the flag.
- R11: After reset, `rx_count` is 0 and `rx_valid`, `rx_overrun` and `rx_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, one cycle per sample tick |
| os_mode | input | 2 | Ticks per bit: 00 = 16, 01 = 8, others = 4 |
| word_sel | input | 2 | Data length 5 + word_sel bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rxd | input | 1 | Serial input, idles high |
| pop | input | 1 | Removes the queue head |
| rx_data | output | 8 | Data of the queue head |
| rx_err_par | output | 1 | Parity tag of the queue head |
| rx_err_frm | output | 1 | Framing tag of the queue head |
| rx_err_brk | output | 1 | Break tag of the queue head |
| rx_valid | output | 1 | Queue holds at least one entry |
| rx_count | output | 5 | Number of entries held |
| rx_overrun | output | 1 | A character was dropped because the queue was full |
| rx_timeout | output | 1 | Data-ready timeout |

## Verification
The checks assume that `os_mode`, `word_sel`, `par_en` and `par_odd` stay fixed while a character is on the line. They also assume that `rxd` changes away from the clock edge and holds each bit for a whole number of tick periods. The head tags are only read while `rx_valid` is high. The stimulus changes the mode inputs only between frames, with the line idle. It drives the serial input on the falling clock edge, for exactly ticks-per-bit times tick spacing cycles per bit. It issues pops only as single-cycle pulses on the falling edge.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  localparam int unsigned CHAR_W      = 8;
  localparam int unsigned OS_MAX_SH   = 4;
  localparam int unsigned TO_MAX_BITS = 4 * CHAR_W + 12;
  localparam int unsigned TO_W        = $clog2((TO_MAX_BITS << OS_MAX_SH) + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  // log2 of ticks per bit
  function automatic logic [2:0] os_shift(input logic [1:0] mode);
    case (mode)
      2'd0:    os_shift = 3'd4;
      2'd1:    os_shift = 3'd3;
      default: os_shift = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
  import sio_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      os_tick,
  input  logic [1:0] os_mode,
  input  logic [1:0] word_sel,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      rxd,
  output logic      ch_push,
  output rx_entry_t ch_entry
);
  rx_state_e         st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [2:0]        idx_q, idx_d;
  logic [CHAR_W-1:0] dat_q, dat_d;
  logic              par_q, par_d;
  logic              line_q, line_d;

  logic [2:0] sh;
  logic [4:0] span;
  logic [3:0] full_last, half_last;
  logic [2:0] idx_last;

  always_comb begin
    sh        = os_shift(os_mode);
    span      = 5'd1 << sh;
    full_last = 4'(span - 5'd1);
    half_last = 4'((span >> 1) - 5'd1);
    idx_last  = 3'd4 + {1'b0, word_sel};
  end

  // entry fields, valid in the stop-sample cycle
  always_comb begin
    ch_entry.data = dat_q;
    ch_entry.frm  = ~rxd;
    ch_entry.par  = par_en & (^dat_q ^ par_q ^ par_odd);
    ch_entry.brk  = (dat_q == '0) & ~(par_en & par_q) & ~rxd;
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    dat_d   = dat_q;
    par_d   = par_q;
    line_d  = line_q;
    ch_push = 1'b0;
    if (os_tick) begin
      line_d = rxd;
      case (st_q)
        ST_IDLE: begin
          if (line_q && !rxd) begin
            st_d  = ST_START;
            cnt_d = '0;
            idx_d = '0;
            dat_d = '0;
            par_d = 1'b0;
          end
        end
        ST_START: begin
          if (cnt_q == half_last) begin
            cnt_d = '0;
            st_d  = rxd ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_DATA: begin
          if (cnt_q == full_last) begin
            cnt_d        = '0;
            dat_d[idx_q] = rxd;
            if (idx_q == idx_last) st_d = par_en ? ST_PAR : ST_STOP;
            else                   idx_d = idx_q + 3'd1;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_PAR: begin
          if (cnt_q == full_last) begin
            cnt_d = '0;
            par_d = rxd;
            st_d  = ST_STOP;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_STOP: begin
          if (cnt_q == full_last) begin
            cnt_d   = '0;
            ch_push = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      par_q  <= 1'b0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      dat_q  <= dat_d;
      par_q  <= par_d;
      line_q <= line_d;
    end
  end

  AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && $past(st_q) == ST_IDLE) |-> !$past(rxd)); // R2
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo
  import sio_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  rx_entry_t                wdata,
  input  logic                     pop,
  output rx_entry_t                head,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     pop_acc
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]     cnt_q, cnt_d;
  logic            wr_en;

  always_comb begin
    full    = (cnt_q == FULL_CNT);
    wr_en   = push & ~full;
    pop_acc = pop & (cnt_q != '0);
    wr_d    = wr_en   ? wr_q + 1'b1 : wr_q;
    rd_d    = pop_acc ? rd_q + 1'b1 : rd_q;
    case ({wr_en, pop_acc})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    count = cnt_q;
    head  = mem[rd_q];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == '0 && !push) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/sio_rx_idle_timer.sv
module sio_rx_idle_timer
  import sio_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [1:0] os_mode,
  input  logic [1:0] word_sel,
  input  logic       has_data,
  input  logic       restart,
  input  logic       clear,
  output logic       timeout
);
  logic [TO_W-1:0] cnt_q, cnt_d, lim;
  logic [5:0]      bits;
  logic            to_q, to_d;

  always_comb begin
    bits = 6'd32 + {2'b00, word_sel, 2'b00};
    lim  = TO_W'(bits) << os_shift(os_mode);
    cnt_d = cnt_q;
    to_d  = to_q;
    if (restart) begin
      cnt_d = '0;
    end else if (os_tick && has_data && !to_q) begin
      if (cnt_q >= lim - 1'b1) to_d  = 1'b1;
      else                     cnt_d = cnt_q + 1'b1;
    end
    if (clear) to_d = 1'b0;
    timeout = to_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(has_data)); // R10
endmodule

// File: rtl/sio_rx_unit.sv
module sio_rx_unit
  import sio_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   os_tick,
  input  logic [1:0]             os_mode,
  input  logic [1:0]             word_sel,
  input  logic                   par_en,
  input  logic                   par_odd,
  input  logic                   rxd,
  input  logic                   pop,
  output logic [CHAR_W-1:0]      rx_data,
  output logic                   rx_err_par,
  output logic                   rx_err_frm,
  output logic                   rx_err_brk,
  output logic                   rx_valid,
  output logic [$clog2(DEPTH):0] rx_count,
  output logic                   rx_overrun,
  output logic                   rx_timeout
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic        ch_push, q_full, q_pop;
  rx_entry_t   ch_entry, q_head;
  logic [AW:0] q_count;
  logic        ovr_q, ovr_d;

  sio_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os_mode(os_mode),
    .word_sel(word_sel), .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
    .ch_push(ch_push), .ch_entry(ch_entry)
  );

  sio_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(ch_push), .wdata(ch_entry), .pop(pop),
    .head(q_head), .count(q_count), .full(q_full), .pop_acc(q_pop)
  );

  sio_rx_idle_timer u_timer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os_mode(os_mode),
    .word_sel(word_sel), .has_data(q_count != '0), .restart(ch_push | q_pop),
    .clear(q_pop), .timeout(rx_timeout)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (q_pop)             ovr_d = 1'b0;
    if (ch_push && q_full) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  always_comb begin
    rx_data    = q_head.data;
    rx_err_par = q_head.par;
    rx_err_frm = q_head.frm;
    rx_err_brk = q_head.brk;
    rx_valid   = (q_count != '0);
    rx_count   = q_count;
    rx_overrun = ovr_q;
  end

  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_push && q_full && !pop) |=> (q_count == (AW + 1)'(DEPTH))); // R9
  AST_BRK_WITH_FRM: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err_brk) |-> rx_err_frm); // R6
endmodule

// File: tb/sio_rx_unit_bench.sv
`timescale 1ns/1ps
module sio_rx_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n, os_tick, par_en, par_odd, rxd, pop;
  logic [1:0] os_mode, word_sel;
  logic [7:0] rx_data;
  logic       rx_err_par, rx_err_frm, rx_err_brk, rx_valid, rx_overrun, rx_timeout;
  logic [4:0] rx_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int tick_div = 1;
  int tick_cnt = 0;

  always #2 clk = ~clk;

  sio_rx_unit u_sio_rx_unit (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os_mode(os_mode),
    .word_sel(word_sel), .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
    .pop(pop), .rx_data(rx_data), .rx_err_par(rx_err_par),
    .rx_err_frm(rx_err_frm), .rx_err_brk(rx_err_brk), .rx_valid(rx_valid),
    .rx_count(rx_count), .rx_overrun(rx_overrun), .rx_timeout(rx_timeout)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] ws;
    logic       pen;
    logic       podd;
    logic [7:0] data;
    logic       bad;
    logic       stopv;
    logic [1:0] tdiv;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 2'd1},
    '{2'd1, 2'd3, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 2'd1},
    '{2'd2, 2'd2, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b1, 2'd1},
    '{2'd0, 2'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 2'd2},
    '{2'd1, 2'd1, 1'b1, 1'b0, 8'h2D, 1'b1, 1'b1, 2'd1},
    '{2'd0, 2'd3, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0, 2'd1},
    '{2'd2, 2'd3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 2'd3},
    '{2'd3, 2'd3, 1'b1, 1'b1, 8'hC3, 1'b0, 1'b1, 2'd1}
  };

  logic [7:0] exp_d   [8];
  logic       exp_par [8];
  logic       exp_frm [8];
  logic       exp_brk [8];

  // tick generator
  initial begin
    os_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (tick_cnt >= tick_div - 1) begin
        os_tick  = 1'b1;
        tick_cnt = 0;
      end else begin
        os_tick  = 1'b0;
        tick_cnt = tick_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pop = 1'b0; rxd = 1'b1;
    os_mode = 2'd0; word_sel = 2'd3; par_en = 1'b0; par_odd = 1'b0;
    tick_div = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive_bit(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] mode, input logic [1:0] ws,
                            input bit pen, input bit pbit, input logic [7:0] d,
                            input bit stopv, input int tdiv, input int tail);
    int ratio;
    int bc;
    ratio = (mode == 2'd0) ? 16 : (mode == 2'd1) ? 8 : 4;
    bc = ratio * tdiv;
    os_mode = mode; word_sel = ws; par_en = pen; tick_div = tdiv;
    drive_bit(1'b0, bc);
    for (int i = 0; i < 5 + int'(ws); i++) drive_bit(d[i], bc);
    if (pen) drive_bit(pbit, bc);
    drive_bit(stopv, bc);
    drive_bit(1'b1, tail * bc);
  endtask

  task automatic pop_once();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    do_reset();
    chk("R11 count", rx_count, 0);
    chk("R11 valid", rx_valid, 0);
    chk("R11 overrun", rx_overrun, 0);
    chk("R11 timeout", rx_timeout, 0);

    // R8: pop on empty
    pop_once();
    chk("R8 count after empty pop", rx_count, 0);
    chk("R8 valid after empty pop", rx_valid, 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      logic [7:0] mask, d;
      logic pbit;
      v = VEC[i];
      mask = 8'((9'd1 << (5 + v.ws)) - 9'd1);
      d = v.data & mask;
      pbit = (^d) ^ v.podd ^ v.bad;
      exp_d[i]   = d;
      exp_par[i] = v.pen & v.bad;
      exp_frm[i] = ~v.stopv;
      exp_brk[i] = (d == 8'h00) && !(v.pen && pbit) && !v.stopv;
      par_odd = v.podd;
      send_frame(v.mode, v.ws, v.pen, pbit, v.data, v.stopv, int'(v.tdiv), 2);
      chk("R7 count grows", rx_count, i + 1);
    end
    for (int i = 0; i < 8; i++) begin
      chk("R1 R3 head data", rx_data, exp_d[i]);
      chk("R4 parity tag", rx_err_par, exp_par[i]);
      chk("R5 framing tag", rx_err_frm, exp_frm[i]);
      chk("R6 break tag", rx_err_brk, exp_brk[i]);
      pop_once();
    end
    chk("R7 drained", rx_count, 0);

    // R2: false start
    do_reset();
    drive_bit(1'b0, 5);
    drive_bit(1'b1, 40);
    chk("R2 false start queued nothing", rx_count, 0);
    send_frame(2'd0, 2'd3, 1'b0, 1'b0, 8'h81, 1'b1, 1, 2);
    chk("R2 recovery count", rx_count, 1);
    chk("R2 recovery data", rx_data, 8'h81);

    // R9: overrun
    do_reset();
    for (int i = 0; i < 16; i++)
      send_frame(2'd2, 2'd3, 1'b0, 1'b0, 8'((i * 17 + 3) & 255), 1'b1, 1, 2);
    chk("R7 full count", rx_count, 16);
    chk("R9 no overrun yet", rx_overrun, 0);
    send_frame(2'd2, 2'd3, 1'b0, 1'b0, 8'hEE, 1'b1, 1, 2);
    chk("R9 count held", rx_count, 16);
    chk("R9 overrun set", rx_overrun, 1);
    chk("R7 head is first", rx_data, 8'h03);
    pop_once();
    chk("R9 overrun cleared", rx_overrun, 0);
    repeat (14) pop_once();
    chk("R9 last kept entry", rx_data, 8'((15 * 17 + 3) & 255));
    pop_once();
    chk("R9 dropped char absent", rx_count, 0);

    // R10: timeout
    do_reset();
    fork
      begin
        send_frame(2'd0, 2'd3, 1'b0, 1'b0, 8'h11, 1'b1, 1, 1);
        send_frame(2'd0, 2'd3, 1'b0, 1'b0, 8'h22, 1'b1, 1, 4);
      end
      begin
        while (rx_count != 5'd2) @(negedge clk);
        repeat (702) @(negedge clk);
        chk("R10 restart on char, not yet", rx_timeout, 0);
        repeat (3) @(negedge clk);
        chk("R10 timeout set", rx_timeout, 1);
      end
    join
    pop_once();
    chk("R10 pop clears", rx_timeout, 0);
    chk("R10 count after pop", rx_count, 1);
    repeat (702) @(negedge clk);
    chk("R10 restart on pop, not yet", rx_timeout, 0);
    repeat (3) @(negedge clk);
    chk("R10 timeout after pop", rx_timeout, 1);
    pop_once();
    repeat (800) @(negedge clk);
    chk("R10 empty queue no timeout", rx_timeout, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule